// File: doc/BRIEF.md
# Boot-Window Command Sequencer

This block sits beside the boot buffer of a flash device. Writes that land in the boot-buffer address window carry data, and they also serve as a command channel. The block watches every write. When the word offset falls in the lower window (0x0000 to 0x01FF) or the upper window (0x8000 to 0x800F), the block decodes the written value.

Three commands are recognised:
- A warm-reset request.
- A read-identification request. It places the identification bytes into boot-buffer words 0 to 2.
- A two-write page-load sequence. The first write arms the sequence. The following window write either fires a load strobe, with a computed sector index, or simply disarms it.

The block also owns the page address register that the load sequence uses. After every triggered load, that register advances by four pages modulo 256. The array access behind the load strobe and the rest of the register bank are outside this block. The bank feeds in the block address, the density mask, the ID values and the write-protect status. It can also write the page register directly, and it can request a reset from another source.

Top module: `boot_cmd_seq`

## Requirements
- R1: A write whose word offset lies outside 0x0000–0x01FF and 0x8000–0x800F has no effect: no strobe fires, and the armed state and the page register are unchanged.
- R2: An unarmed window write of 0x00F0 produces a one-cycle `warm_rst_o` pulse in the cycle after the write. The same edge clears the page register to 0.
- R3: An unarmed window write of 0x00E0 sets `armed_o` from the next cycle on.
- R4: While armed, a window write of 0x0000 produces a one-cycle `load_stb_o` pulse in the next cycle and clears `armed_o`.
- R5: While armed, any window write of a value other than 0x0000 clears `armed_o` and does nothing else. This includes 0x00F0, 0x00E0 and 0x0090.
- R6: With a load strobe, `load_sector_o` is set as follows:
  - Let B be block-address bits 11:0. If block-address bit 15 is set, OR the density mask into B.
  - Compute ((B·64 + page[7:2])·4) + page[1:0].
  - The page value used is the one before the advance.
- R7: Each triggered load advances the page register by 4, modulo 256.
- R8: An unarmed window write of 0x0090 produces a one-cycle `id_wr_o` pulse in the next cycle. With it come word 0 = 0x00 followed by the manufacturer ID low byte, word 1 = 0x00 followed by the device ID low byte, and word 2 = 0x00 followed by the write-protect status low byte.
- R9: Any other unarmed window value produces only a one-cycle `unk_cmd_o` pulse.
- R10: `ext_rst_i` clears the armed state and the page register. It takes priority over, and discards, a window write in the same cycle.
- R11: `pg_we_i` loads the page register. It wins over a load advance in the same cycle and loses to any reset request.
- R12: After `rst_n` is released, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| wr_addr_i | input | 16 | Word offset of the write |
| wr_data_i | input | 16 | Written value |
| ext_rst_i | input | 1 | Reset request from another source |
| pg_we_i | input | 1 | Direct page-register write |
| pg_wdata_i | input | 8 | Page value for the direct write |
| blk_addr_i | input | 16 | Block address (bit 15 selects density mask) |
| dens_mask_i | input | 12 | Density mask ORed into the block number |
| mfr_id_i | input | 16 | Manufacturer ID |
| dev_id_i | input | 16 | Device ID |
| wp_stat_i | input | 16 | Write-protect status |
| warm_rst_o | output | 1 | Warm-reset strobe |
| load_stb_o | output | 1 | Page-load strobe |
| load_sector_o | output | 20 | Sector index of the load |
| page_o | output | 8 | Page address register |
| armed_o | output | 1 | Second-write pending |
| unk_cmd_o | output | 1 | Unknown-command strobe |
| id_wr_o | output | 1 | Identification write strobe |
| id_word0_o | output | 16 | Boot word 0 value |
| id_word1_o | output | 16 | Boot word 1 value |
| id_word2_o | output | 16 | Boot word 2 value |

## Verification
The bench builds the block with its default parameters: 16-bit addresses and data, a 12-bit block number, an 8-bit page register and the upper window enabled. With these values the window edges are reachable, on both sides of each range. So are a density mask landing on block bit 11 and a page register that wraps from 0xFC to 0x00. The reference model tracks the armed state and the page register on every edge. It is driven through back-to-back sequences that interleave resets, direct page writes and armed writes.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

   localparam logic [15:0] CMD_WARM_RST = 16'h00F0;
   localparam logic [15:0] CMD_LOAD_ARM = 16'h00E0;
   localparam logic [15:0] CMD_READ_ID  = 16'h0090;
   localparam logic [15:0] CMD_LOAD_GO  = 16'h0000;

   localparam int ID_WORDS = 3;

   typedef enum logic [2:0] {
      ACT_NONE,
      ACT_WARM,
      ACT_ARM,
      ACT_LOAD,
      ACT_ID,
      ACT_UNK,
      ACT_DISARM
   } act_e;

endpackage

// File: rtl/bcs_win_dec.sv
module bcs_win_dec #(
   parameter int                ADDR_W  = 16,
   parameter logic [ADDR_W-1:0] LO_END  = 16'h01FF,
   parameter logic [ADDR_W-1:0] HI_BASE = 16'h8000,
   parameter logic [ADDR_W-1:0] HI_END  = 16'h800F,
   parameter bit                HI_EN   = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              hit_o
);

   logic lo_hit;

   assign lo_hit = (addr_i <= LO_END);

   generate
      if (HI_EN) begin : g_two_win
         if (HI_BASE > HI_END) begin : g_bad_range
            $error("upper window base above its end");
         end
         if (HI_BASE <= LO_END) begin : g_overlap
            $error("upper window overlaps lower window");
         end
         logic hi_hit;
         assign hi_hit = (addr_i >= HI_BASE) && (addr_i <= HI_END);
         assign hit_o  = lo_hit | hi_hit;
      end else begin : g_one_win
         assign hit_o = lo_hit;
      end
   endgenerate

endmodule

// File: rtl/bcs_cmd_ctl.sv
module bcs_cmd_ctl
   import bcs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_rst_i,
   input  logic              hit_wr_i,
   input  logic [DATA_W-1:0] data_i,
   output act_e              act_o,
   output logic              armed_o,
   output logic              warm_o,
   output logic              load_o,
   output logic              id_o,
   output logic              unk_o
);

   generate
      if (DATA_W < 16) begin : g_bad_width
         $error("command width must be at least 16 bits");
      end
   endgenerate

   act_e act;
   logic armed_q, armed_d;
   logic warm_q, load_q, id_q, unk_q;

   always_comb begin
      act     = ACT_NONE;
      armed_d = armed_q;
      if (ext_rst_i) begin
         armed_d = 1'b0;
      end else if (hit_wr_i) begin
         if (armed_q) begin
            armed_d = 1'b0;
            act     = (data_i == DATA_W'(CMD_LOAD_GO)) ? ACT_LOAD : ACT_DISARM;
         end else if (data_i == DATA_W'(CMD_WARM_RST)) begin
            act = ACT_WARM;
         end else if (data_i == DATA_W'(CMD_LOAD_ARM)) begin
            act     = ACT_ARM;
            armed_d = 1'b1;
         end else if (data_i == DATA_W'(CMD_READ_ID)) begin
            act = ACT_ID;
         end else begin
            act = ACT_UNK;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         warm_q  <= 1'b0;
         load_q  <= 1'b0;
         id_q    <= 1'b0;
         unk_q   <= 1'b0;
      end else begin
         armed_q <= armed_d;
         warm_q  <= (act == ACT_WARM);
         load_q  <= (act == ACT_LOAD);
         id_q    <= (act == ACT_ID);
         unk_q   <= (act == ACT_UNK);
      end
   end

   assign act_o   = act;
   assign armed_o = armed_q;
   assign warm_o  = warm_q;
   assign load_o  = load_q;
   assign id_o    = id_q;
   assign unk_o   = unk_q;

   // R4: a load strobe only follows a cycle spent armed
   a_r4_load_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
      load_q |-> $past(armed_q));

   // R9: strobes are mutually exclusive
   a_r9_strobes_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({warm_q, load_q, id_q, unk_q}));

   // R5: any window write while armed ends the armed state
   a_r5_second_write_disarms: assert property (@(posedge clk) disable iff (!rst_n)
      (armed_q && hit_wr_i) |=> !armed_q);

   // R10: an external reset leaves nothing armed and fires no strobe
   a_r10_ext_rst_clears: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rst_i |=> (!armed_q && !warm_q && !load_q && !id_q && !unk_q));

   // R2: a warm reset never coincides with an armed state
   a_r2_warm_not_armed: assert property (@(posedge clk) disable iff (!rst_n)
      warm_q |-> !armed_q);

endmodule

// File: rtl/bcs_page_trk.sv
module bcs_page_trk #(
   parameter int BA_W  = 16,
   parameter int BLK_W = 12,
   parameter int PG_W  = 8,
   parameter int STEP  = 4,
   localparam int SEC_W = BLK_W + PG_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic             pg_we_i,
   input  logic [PG_W-1:0]  pg_wdata_i,
   input  logic [BA_W-1:0]  blk_addr_i,
   input  logic [BLK_W-1:0] dens_mask_i,
   output logic [PG_W-1:0]  page_o,
   output logic [SEC_W-1:0] sector_o
);

   generate
      if (BLK_W >= BA_W) begin : g_bad_blk
         $error("block number must leave room for the density flag bit");
      end
      if (PG_W < 3) begin : g_bad_pg
         $error("page register too narrow");
      end
   endgenerate

   logic [PG_W-1:0]  page_q;
   logic [SEC_W-1:0] sector_q;
   logic [BLK_W-1:0] blk_num;

   assign blk_num = blk_addr_i[BLK_W-1:0] |
                    (blk_addr_i[BA_W-1] ? dens_mask_i : '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q <= '0;
      end else if (clr_i) begin
         page_q <= '0;
      end else if (pg_we_i) begin
         page_q <= pg_wdata_i;
      end else if (adv_i) begin
         page_q <= page_q + PG_W'(STEP);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sector_q <= '0;
      end else if (adv_i && !clr_i) begin
         sector_q <= {blk_num, page_q};
      end
   end

   assign page_o   = page_q;
   assign sector_o = sector_q;

   // R7: a bare advance moves the page forward by the step, wrapping
   a_r7_page_advance: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !clr_i && !pg_we_i) |=> (page_q == $past(page_q) + PG_W'(STEP)));

   // R10: a reset request empties the page register
   a_r10_page_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (page_q == '0));

   // R11: a direct write that is not overridden by reset lands
   a_r11_page_write: assert property (@(posedge clk) disable iff (!rst_n)
      (pg_we_i && !clr_i) |=> (page_q == $past(pg_wdata_i)));

endmodule

// File: rtl/bcs_id_fill.sv
module bcs_id_fill
   import bcs_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           go_i,
   input  logic [ID_WORDS-1:0][DATA_W-1:0] src_i,
   output logic                           wr_o,
   output logic [ID_WORDS-1:0][DATA_W-1:0] word_o
);

   logic wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_q <= 1'b0;
      else        wr_q <= go_i;
   end

   genvar gi;
   generate
      for (gi = 0; gi < ID_WORDS; gi++) begin : g_word
         logic [DATA_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    word_q <= '0;
            else if (go_i) word_q <= {{(DATA_W-8){1'b0}}, src_i[gi][7:0]};
         end
         assign word_o[gi] = word_q;
      end
   endgenerate

   assign wr_o = wr_q;

   // R8: each filled word keeps only the low byte of its source
   a_r8_upper_byte_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_q |-> (word_o[0][DATA_W-1:8] == '0 && word_o[1][DATA_W-1:8] == '0
                && word_o[2][DATA_W-1:8] == '0));

endmodule

// File: rtl/boot_cmd_seq.sv
module boot_cmd_seq
   import bcs_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 16,
   parameter int BA_W   = 16,
   parameter int BLK_W  = 12,
   parameter int PG_W   = 8,
   parameter int STEP   = 4,
   parameter bit HI_EN  = 1'b1,
   localparam int SEC_W = BLK_W + PG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              ext_rst_i,
   input  logic              pg_we_i,
   input  logic [PG_W-1:0]   pg_wdata_i,
   input  logic [BA_W-1:0]   blk_addr_i,
   input  logic [BLK_W-1:0]  dens_mask_i,
   input  logic [DATA_W-1:0] mfr_id_i,
   input  logic [DATA_W-1:0] dev_id_i,
   input  logic [DATA_W-1:0] wp_stat_i,
   output logic              warm_rst_o,
   output logic              load_stb_o,
   output logic [SEC_W-1:0]  load_sector_o,
   output logic [PG_W-1:0]   page_o,
   output logic              armed_o,
   output logic              unk_cmd_o,
   output logic              id_wr_o,
   output logic [DATA_W-1:0] id_word0_o,
   output logic [DATA_W-1:0] id_word1_o,
   output logic [DATA_W-1:0] id_word2_o
);

   logic hit;
   logic hit_wr;
   act_e act;
   logic [ID_WORDS-1:0][DATA_W-1:0] id_src;
   logic [ID_WORDS-1:0][DATA_W-1:0] id_word;

   bcs_win_dec #(
      .ADDR_W  (ADDR_W),
      .LO_END  (ADDR_W'(16'h01FF)),
      .HI_BASE (ADDR_W'(16'h8000)),
      .HI_END  (ADDR_W'(16'h800F)),
      .HI_EN   (HI_EN)
   ) u_win (
      .addr_i (wr_addr_i),
      .hit_o  (hit)
   );

   assign hit_wr = wr_en_i & hit;

   bcs_cmd_ctl #(.DATA_W(DATA_W)) u_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .ext_rst_i (ext_rst_i),
      .hit_wr_i  (hit_wr),
      .data_i    (wr_data_i),
      .act_o     (act),
      .armed_o   (armed_o),
      .warm_o    (warm_rst_o),
      .load_o    (load_stb_o),
      .id_o      (id_wr_o),
      .unk_o     (unk_cmd_o)
   );

   bcs_page_trk #(
      .BA_W  (BA_W),
      .BLK_W (BLK_W),
      .PG_W  (PG_W),
      .STEP  (STEP)
   ) u_page (
      .clk         (clk),
      .rst_n       (rst_n),
      .clr_i       (ext_rst_i || (act == ACT_WARM)),
      .adv_i       (act == ACT_LOAD),
      .pg_we_i     (pg_we_i),
      .pg_wdata_i  (pg_wdata_i),
      .blk_addr_i  (blk_addr_i),
      .dens_mask_i (dens_mask_i),
      .page_o      (page_o),
      .sector_o    (load_sector_o)
   );

   assign id_src[0] = mfr_id_i;
   assign id_src[1] = dev_id_i;
   assign id_src[2] = wp_stat_i;

   bcs_id_fill #(.DATA_W(DATA_W)) u_id (
      .clk    (clk),
      .rst_n  (rst_n),
      .go_i   (act == ACT_ID),
      .src_i  (id_src),
      .wr_o   (),
      .word_o (id_word)
   );

   assign id_word0_o = id_word[0];
   assign id_word1_o = id_word[1];
   assign id_word2_o = id_word[2];

   // R1: a write outside the window leaves the armed state alone
   a_r1_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !hit && !ext_rst_i) |=> (armed_o == $past(armed_o)));

endmodule

// File: tb/sim_boot_cmd_seq.sv
module sim_boot_cmd_seq;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [15:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic        ext_rst = 1'b0;
   logic        pg_we = 1'b0;
   logic [7:0]  pg_wdata = '0;
   logic [15:0] blk_addr = '0;
   logic [11:0] dens_mask = '0;
   logic [15:0] mfr_id = 16'hA5EC;
   logic [15:0] dev_id = 16'h3F40;
   logic [15:0] wp_stat = 16'h0002;

   logic        warm_rst, load_stb, armed, unk_cmd, id_wr;
   logic [19:0] load_sector;
   logic [7:0]  page;
   logic [15:0] idw0, idw1, idw2;

   always #2 clk = ~clk;

   boot_cmd_seq u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .wr_en_i       (wr_en),
      .wr_addr_i     (wr_addr),
      .wr_data_i     (wr_data),
      .ext_rst_i     (ext_rst),
      .pg_we_i       (pg_we),
      .pg_wdata_i    (pg_wdata),
      .blk_addr_i    (blk_addr),
      .dens_mask_i   (dens_mask),
      .mfr_id_i      (mfr_id),
      .dev_id_i      (dev_id),
      .wp_stat_i     (wp_stat),
      .warm_rst_o    (warm_rst),
      .load_stb_o    (load_stb),
      .load_sector_o (load_sector),
      .page_o        (page),
      .armed_o       (armed),
      .unk_cmd_o     (unk_cmd),
      .id_wr_o       (id_wr),
      .id_word0_o    (idw0),
      .id_word1_o    (idw1),
      .id_word2_o    (idw2)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   // reference model state
   int m_armed = 0, m_page = 0;
   int e_warm, e_load, e_sec, e_id, e_unk, e_w0, e_w1, e_w2;

   task automatic chk(input bit ok, input string tag, input longint act_v, input longint exp_v);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   function automatic bit in_win(input int a);
      return (a <= 'h01FF) || (a >= 'h8000 && a <= 'h800F);
   endfunction

   task automatic model();
      int blkn;
      bit rst_now;
      bit adv;
      rst_now = 0;
      adv = 0;
      e_warm = 0; e_load = 0; e_id = 0; e_unk = 0;
      if (ext_rst) begin
         m_armed = 0;
         m_page = 0;
      end else begin
         if (wr_en && in_win(int'(wr_addr))) begin
            if (m_armed != 0) begin
               m_armed = 0;
               if (wr_data == 16'h0000) begin
                  e_load = 1;
                  blkn = int'(blk_addr & 16'h0FFF);
                  if (blk_addr[15]) blkn = blkn | int'(dens_mask);
                  e_sec = (((blkn * 64) + (m_page / 4)) * 4) + (m_page % 4);
                  adv = 1;
               end
            end else begin
               case (wr_data)
                  16'h00F0: begin e_warm = 1; rst_now = 1; m_page = 0; end
                  16'h00E0: m_armed = 1;
                  16'h0090: begin
                     e_id = 1;
                     e_w0 = int'(mfr_id) % 256;
                     e_w1 = int'(dev_id) % 256;
                     e_w2 = int'(wp_stat) % 256;
                  end
                  default: e_unk = 1;
               endcase
            end
         end
         if (!rst_now) begin
            if (pg_we)    m_page = int'(pg_wdata);
            else if (adv) m_page = (m_page + 4) % 256;
         end
      end
   endtask

   task automatic compare();
      chk(warm_rst == e_warm[0], "R2 warm_rst", warm_rst, e_warm);
      chk(load_stb == e_load[0], "R4 load_stb", load_stb, e_load);
      if (e_load != 0) chk(int'(load_sector) == e_sec, "R6 load_sector", load_sector, e_sec);
      chk(int'(page) == m_page, "R7 page", page, m_page);
      chk(armed == m_armed[0], "R3 armed", armed, m_armed);
      chk(id_wr == e_id[0], "R8 id_wr", id_wr, e_id);
      if (e_id != 0) begin
         chk(int'(idw0) == e_w0, "R8 word0", idw0, e_w0);
         chk(int'(idw1) == e_w1, "R8 word1", idw1, e_w1);
         chk(int'(idw2) == e_w2, "R8 word2", idw2, e_w2);
      end
      chk(unk_cmd == e_unk[0], "R9 unk_cmd", unk_cmd, e_unk);
   endtask

   task automatic cyc();
      @(posedge clk);
      model();
      #1;
      compare();
   endtask

   task automatic wr(input logic [15:0] a, input logic [15:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic pgw(input logic [7:0] v);
      pg_we = 1'b1; pg_wdata = v;
      cyc();
      pg_we = 1'b0;
   endtask

   task automatic load_seq(input logic [15:0] a1, input logic [15:0] a2);
      wr(a1, 16'h00E0);
      wr(a2, 16'h0000);
   endtask

   initial begin
      #400000;
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #9;
      // R12: reset state
      chk(!warm_rst && !load_stb && !armed && !unk_cmd && !id_wr, "R12 strobes in reset",
          {warm_rst, load_stb, armed, unk_cmd, id_wr}, 0);
      chk(page == 8'h00 && load_sector == '0, "R12 page/sector in reset", page, 0);
      chk(idw0 == '0 && idw1 == '0 && idw2 == '0, "R12 id words in reset", idw0, 0);
      @(negedge clk);
      rst_n = 1'b1;
      cyc();
      cyc();

      // R3 / R4 / R6 / R7: basic load, lower window, density flag clear
      blk_addr = 16'h0ABC; dens_mask = 12'hFFF;
      pgw(8'h05);
      load_seq(16'h0000, 16'h01FF);
      chk(page == 8'h09, "R7 page after first load", page, 9);

      // R6: density mask applied when flag bit set, upper window both edges
      blk_addr = 16'h8123; dens_mask = 12'h800;
      load_seq(16'h8000, 16'h800F);
      chk(load_sector == 20'h92309 || !load_stb, "R6 masked sector", load_sector, 20'h92309);

      // R7: wrap modulo 256
      pgw(8'hFC);
      load_seq(16'h0100, 16'h8007);
      chk(page == 8'h00, "R7 page wraps", page, 0);
      load_seq(16'h0001, 16'h0002);
      load_seq(16'h0003, 16'h0004);

      // R1: outside-window writes have no effect
      wr(16'h0200, 16'h00F0);
      wr(16'h7FFF, 16'h00E0);
      wr(16'h8010, 16'h0090);
      wr(16'hF220, 16'h1234);
      chk(!armed && page == 8'h08, "R1 outside window ignored", page, 8);

      // R1: armed state survives an outside write
      wr(16'h0010, 16'h00E0);
      wr(16'h0300, 16'h0000);
      chk(armed == 1'b1, "R1 armed kept across outside write", armed, 1);
      wr(16'h0011, 16'h0000);

      // R5: armed then non-zero values only disarm
      wr(16'h0000, 16'h00E0);
      wr(16'h0000, 16'h00F0);
      chk(!armed && page == 8'h0C, "R5 armed F0 only disarms", page, 8'h0C);
      wr(16'h0000, 16'h00E0);
      wr(16'h8001, 16'h0090);
      wr(16'h0000, 16'h00E0);
      wr(16'h8001, 16'h00E0);
      chk(!armed, "R5 armed E0 disarms", armed, 0);

      // R8: identification fill, two source sets
      wr(16'h0050, 16'h0090);
      mfr_id = 16'h12FE; dev_id = 16'hFF01; wp_stat = 16'h0104;
      wr(16'h800C, 16'h0090);

      // R9: unknown values
      wr(16'h0020, 16'h1234);
      wr(16'h0020, 16'h00F1);
      wr(16'h8002, 16'hFFFF);

      // R2: warm reset clears page
      pgw(8'h33);
      wr(16'h0000, 16'h00F0);
      chk(page == 8'h00, "R2 warm reset clears page", page, 0);

      // R10: external reset clears armed and page, discards window write
      pgw(8'h44);
      wr(16'h0000, 16'h00E0);
      ext_rst = 1'b1;
      wr(16'h0000, 16'h0090);
      ext_rst = 1'b0;
      chk(!armed && page == 8'h00 && !id_wr, "R10 ext reset dominates", page, 0);
      wr(16'h0000, 16'h0000);

      // R11: page write beats advance, loses to reset
      wr(16'h0000, 16'h00E0);
      pg_we = 1'b1; pg_wdata = 8'h70;
      wr(16'h0000, 16'h0000);
      pg_we = 1'b0;
      chk(page == 8'h70, "R11 page write beats advance", page, 8'h70);
      pg_we = 1'b1; pg_wdata = 8'h21;
      wr(16'h0000, 16'h00F0);
      pg_we = 1'b0;
      chk(page == 8'h00, "R11 warm reset beats page write", page, 0);
      pg_we = 1'b1; pg_wdata = 8'h22; ext_rst = 1'b1;
      cyc();
      pg_we = 1'b0; ext_rst = 1'b0;
      chk(page == 8'h00, "R11 ext reset beats page write", page, 0);

      // back-to-back mixed traffic
      for (int i = 0; i < 40; i++) begin
         blk_addr = 16'(i * 16'h0913);
         dens_mask = 12'(i * 12'h151);
         load_seq(16'(i), 16'(16'h8000 + (i % 16)));
      end
      cyc();
      cyc();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
      $finish;
   end

endmodule